// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

This block arbitrates eight interrupt inputs for a processor and hands it an 8-bit vector for the winning input. Software talks to it through a byte-wide register port with a single address bit (even and odd). A short run of initialization words sets the vector base, the cascade arrangement and how interrupts are retired. After that, the odd address reaches the mask register and the even address takes commands that retire interrupts or choose which register an even-address read returns.

Two copies can be chained. The upper one raises its output when any input is pending. On the acknowledge, the winner is chosen by fixed priority and moved into the in-service register, and a vector equal to the base plus the input number comes back one cycle later. When the winner is an input that has a second controller behind it, the upper controller drives that input's number on a 3-bit cascade bus and stays silent. The lower controller whose identity matches the bus supplies the vector. An acknowledge that finds nothing pending returns the vector of input 7 and leaves the in-service register untouched.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: An even-address write with bit 4 set (the first init word) clears the mask, in-service and request registers, selects the request register for even-address reads, and starts the sequence. The next odd write is the vector base. A cascade word follows only when bit 1 of the first word is 0. A mode word follows last, and only when bit 0 of the first word is 1. After the sequence, odd writes go to the mask. After reset the mask is 0xFF.
- R2: The vector is the base with its low 3 bits replaced by the input number. A base of 0x20 maps inputs 0..7 to 0x20..0x27.
- R3: The mask register is read and written at the odd address. A set mask bit keeps that input from raising the interrupt output.
- R4: Input 0 has the highest priority and input 7 the lowest. A pending unmasked input raises the output only if no in-service bit of equal or higher priority is set.
- R5: When bit 3 of the first init word is 0, a request bit is set on a rising input edge, stays set while the input stays high, and clears when the input falls or when an acknowledge takes it. When bit 3 is 1, the request register follows the inputs.
- R6: An acknowledge pulse moves the winning input from the request register into the in-service register. In the next cycle the vector valid output is high and the vector is driven.
- R7: Command 0x0B at the even address makes even reads return the in-service register. Command 0x0A makes them return the request register.
- R8: Command 0x60+n at the even address clears in-service bit n and no other bit.
- R9: Command 0x20 at the even address clears the highest-priority in-service bit.
- R10: When bit 1 of the mode word is 1, the in-service bit set by an acknowledge is cleared at the clock edge that ends the vector cycle.
- R11: An acknowledge with no forwarded request returns the base plus 7 and changes no in-service bit.
- R12: In the upper role, the cascade word is a bitmask of inputs that have a lower controller. When the winner is one of these inputs, its in-service bit is set, its number is driven on the cascade bus, and no vector is driven. In the lower role, the low 3 bits of the cascade word are its identity, and it answers an acknowledge only when the cascade bus equals that identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr_odd | input | 1 | Register address bit: 0 even, 1 odd |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to the processor or to the upper controller |
| ack | input | 1 | Acknowledge pulse, one cycle |
| vec_valid | output | 1 | Vector is being driven |
| vec_out | output | 8 | Interrupt vector |
| slave_role | input | 1 | 1 when this copy sits behind another controller |
| cas_in | input | 3 | Cascade bus from the upper controller |
| cas_out | output | 3 | Cascade bus driven toward lower controllers |
| cas_drive | output | 1 | Cascade bus carries a valid number |

## Verification
The bench builds a chained pair with default settings. The upper copy uses base 0x20 and has the lower copy on input 2. The lower copy uses base 0x28 and identity 2. With this pair, every upper input and every input routed through the cascade is swept, as is every ordered pair of upper inputs for nesting priority. The upper copy is then initialized again for automatic retirement, for single mode with base 0x30, and for level mode. This reaches the paths where the sequence skips words and where spurious vectors are returned.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr_odd,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  input  logic       slave_role,
  input  logic [2:0] cas_in,
  output logic [2:0] cas_out,
  output logic       cas_drive
);
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CAS, ST_MODE} seq_t;

  seq_t       seq;
  logic [7:0] irr, isr, imr, prev_in, cas_cfg, aeoi_clr;
  logic [4:0] base;
  logic       cfg_level, cfg_single, cfg_w4, cfg_aeoi, sel_isr;

  logic [7:0] pend;
  logic [2:0] win_idx, top_idx;
  logic       found, stop, top_found;

  assign pend = irr & ~imr;

  always_comb begin
    found = 1'b0; stop = 1'b0; win_idx = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (!stop) begin
        if (isr[i]) stop = 1'b1;
        else if (pend[i]) begin found = 1'b1; win_idx = 3'(i); stop = 1'b1; end
      end
    end
  end

  always_comb begin
    top_found = 1'b0; top_idx = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (isr[i]) begin top_found = 1'b1; top_idx = 3'(i); end
  end

  logic       win_cas, selected, take, wr_even, icw1, ocw2, ocw3;
  logic [7:0] win_hot, eoi_clr, irr_nx;

  assign win_hot   = 8'(1) << win_idx;
  assign win_cas   = !cfg_single && !slave_role && cas_cfg[win_idx];
  assign selected  = !slave_role || cfg_single || (cas_in == cas_cfg[2:0]);
  assign take      = ack && selected && (seq == ST_RUN);
  assign int_out   = found;
  assign cas_out   = win_idx;
  assign cas_drive = take && found && win_cas;

  assign wr_even = wr_en && !addr_odd;
  assign icw1    = wr_even && wr_data[4];
  assign ocw2    = wr_even && !wr_data[4] && !wr_data[3];
  assign ocw3    = wr_even && !wr_data[4] && wr_data[3];

  always_comb begin
    eoi_clr = 8'h00;
    if (ocw2 && wr_data[7:5] == 3'b011) eoi_clr = 8'(1) << wr_data[2:0];
    if (ocw2 && wr_data[7:5] == 3'b001 && top_found) eoi_clr = 8'(1) << top_idx;
  end

  always_comb begin
    irr_nx = cfg_level ? irq_in : ((irr | (irq_in & ~prev_in)) & irq_in);
    if (take && found) irr_nx = irr_nx & ~win_hot;
  end

  assign rd_data = addr_odd ? imr : (sel_isr ? isr : irr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= ST_RUN; irr <= '0; isr <= '0; imr <= 8'hFF; prev_in <= '0;
      cas_cfg <= '0; aeoi_clr <= '0; base <= '0;
      cfg_level <= 1'b0; cfg_single <= 1'b0; cfg_w4 <= 1'b0; cfg_aeoi <= 1'b0;
      sel_isr <= 1'b0; vec_valid <= 1'b0; vec_out <= '0;
    end else begin
      prev_in   <= irq_in;
      vec_valid <= take && !(found && win_cas);
      vec_out   <= {base, found ? win_idx : 3'd7};
      aeoi_clr  <= (take && found && cfg_aeoi) ? win_hot : 8'h00;
      if (icw1) begin
        seq <= ST_BASE; irr <= '0; isr <= '0; imr <= '0; sel_isr <= 1'b0;
        aeoi_clr <= '0; cfg_aeoi <= 1'b0;
        cfg_level <= wr_data[3]; cfg_single <= wr_data[1]; cfg_w4 <= wr_data[0];
      end else begin
        irr <= irr_nx;
        isr <= (isr & ~eoi_clr & ~aeoi_clr) | ((take && found) ? win_hot : 8'h00);
        if (ocw3 && wr_data[1]) sel_isr <= wr_data[0];
        if (wr_en && addr_odd) begin
          case (seq)
            ST_BASE: begin
              base <= wr_data[7:3];
              seq  <= !cfg_single ? ST_CAS : (cfg_w4 ? ST_MODE : ST_RUN);
            end
            ST_CAS: begin
              cas_cfg <= wr_data;
              seq     <= cfg_w4 ? ST_MODE : ST_RUN;
            end
            ST_MODE: begin
              cfg_aeoi <= wr_data[1];
              seq      <= ST_RUN;
            end
            default: imr <= wr_data;
          endcase
        end
      end
    end
  end
endmodule

module cascade_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr_odd,
  input logic [7:0] wr_data,
  input logic       ack,
  input logic       int_out,
  input logic       vec_valid,
  input logic [7:0] vec_out,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic [4:0] base,
  input logic [7:0] aeoi_clr
);
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack)); // R6
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_out[7:3] == base); // R2
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != 8'h00); // R3
  AST_SPURIOUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !wr_en && aeoi_clr == 8'h00) |=> isr == $past(isr)); // R11
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_odd && wr_data[4]) |=> (imr == 8'h00 && isr == 8'h00 && irr == 8'h00)); // R1
  AST_EOI_SPECIFIC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_odd && wr_data[7:3] == 5'b01100 && !ack) |=> !isr[$past(wr_data[2:0])]); // R8
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_odd(addr_odd), .wr_data(wr_data),
  .ack(ack), .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
  .irr(irr), .isr(isr), .imr(imr), .base(base), .aeoi_clr(aeoi_clr)
);

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, ack = 1'b0, addr_odd = 1'b0;
  logic       m_wr = 1'b0, s_wr = 1'b0;
  logic [7:0] wr_data = '0, m_irq = '0, s_irq = '0;
  logic [7:0] m_rd, s_rd, m_vec, s_vec;
  logic       m_int, s_int, m_vv, s_vv, m_cd, s_cd;
  logic [2:0] m_cas, s_cas;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(m_wr), .addr_odd(addr_odd), .wr_data(wr_data),
    .rd_data(m_rd), .irq_in({m_irq[7:3], s_int, m_irq[1:0]}), .int_out(m_int),
    .ack(ack), .vec_valid(m_vv), .vec_out(m_vec), .slave_role(1'b0), .cas_in(3'd0),
    .cas_out(m_cas), .cas_drive(m_cd));

  cascade_irq_ctrl i_cascade_irq_ctrl_s (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .addr_odd(addr_odd), .wr_data(wr_data),
    .rd_data(s_rd), .irq_in(s_irq), .int_out(s_int),
    .ack(ack), .vec_valid(s_vv), .vec_out(s_vec), .slave_role(1'b1), .cas_in(m_cas),
    .cas_out(s_cas), .cas_drive(s_cd));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input bit sl, input bit a, input logic [7:0] d);
    @(negedge clk);
    addr_odd = a; wr_data = d;
    if (sl) s_wr = 1'b1; else m_wr = 1'b1;
    @(negedge clk);
    m_wr = 1'b0; s_wr = 1'b0;
  endtask

  task automatic rreg(input bit sl, input bit a, output logic [7:0] v);
    @(negedge clk);
    addr_odd = a;
    #1 v = sl ? s_rd : m_rd;
  endtask

  task automatic do_ack(output logic vv, output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1 vv = m_vv | s_vv; v = m_vv ? m_vec : s_vec;
  endtask

  task automatic ack_expect(input string tag, input logic [7:0] exp);
    logic vv; logic [7:0] v;
    do_ack(vv, v);
    chk({tag, " valid"}, {7'd0, vv}, 8'h01);
    chk(tag, v, exp);
  endtask

  task automatic read_isr(input bit sl, output logic [7:0] v);
    wreg(sl, 1'b0, 8'h0B);
    rreg(sl, 1'b0, v);
  endtask

  task automatic read_irr(input bit sl, output logic [7:0] v);
    wreg(sl, 1'b0, 8'h0A);
    rreg(sl, 1'b0, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk("R3 reset int", {7'd0, m_int}, 8'h00);
    rreg(0, 1'b1, v); chk("R1 reset mask", v, 8'hFF);
    rreg(0, 1'b0, v); chk("R5 reset irr", v, 8'h00);

    // init master and slave
    wreg(0, 0, 8'h11); wreg(0, 1, 8'h20); wreg(0, 1, 8'h04); wreg(0, 1, 8'h01);
    wreg(1, 0, 8'h11); wreg(1, 1, 8'h28); wreg(1, 1, 8'h02); wreg(1, 1, 8'h01);
    rreg(0, 1'b1, v); chk("R1 mask after init", v, 8'h00);
    rreg(1, 1'b1, v); chk("R1 slave mask after init", v, 8'h00);
    read_isr(0, v); chk("R1 isr after init", v, 8'h00);
    wreg(0, 0, 8'h0A);

    // edge hold and drop
    @(negedge clk); m_irq[3] = 1'b1; tick(1);
    rreg(0, 1'b0, v); chk("R5 irr set on edge", v, 8'h08);
    @(negedge clk); m_irq[3] = 1'b0; tick(1);
    rreg(0, 1'b0, v); chk("R5 irr clears on drop", v, 8'h00);

    // sweep master inputs
    for (int n = 0; n < 8; n++) begin
      if (n != 2) begin
        @(negedge clk); m_irq[n] = 1'b1; tick(1);
        chk("R4 int raised", {7'd0, m_int}, 8'h01);
        ack_expect("R2 R6 vector", 8'h20 + 8'(n));
        read_irr(0, v); chk("R6 irr cleared by ack", v, 8'h00);
        read_isr(0, v); chk("R7 R6 isr after ack", v, 8'(1) << n);
        wreg(0, 0, 8'h60 + 8'(n));
        rreg(0, 1'b0, v); chk("R8 specific eoi", v, 8'h00);
        wreg(0, 0, 8'h0A);
        @(negedge clk); m_irq[n] = 1'b0; tick(1);
      end
    end

    // sweep slave inputs through the cascade
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); s_irq[n] = 1'b1; tick(2);
      chk("R12 master int via slave", {7'd0, m_int}, 8'h01);
      ack_expect("R12 slave vector", 8'h28 + 8'(n));
      read_isr(0, v); chk("R12 master isr cascade bit", v, 8'h04);
      read_isr(1, v); chk("R12 slave isr", v, 8'(1) << n);
      wreg(1, 0, 8'h60 + 8'(n)); wreg(0, 0, 8'h62);
      rreg(0, 1'b0, v); chk("R8 master isr clear", v, 8'h00);
      wreg(0, 0, 8'h0A); wreg(1, 0, 8'h0A);
      @(negedge clk); s_irq[n] = 1'b0; tick(2);
    end

    // nesting priority over ordered pairs
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < 8; i++) begin
        if (i != j && i != 2 && j != 2) begin
          @(negedge clk); m_irq[j] = 1'b1; tick(1);
          ack_expect("R4 first", 8'h20 + 8'(j));
          @(negedge clk); m_irq[i] = 1'b1; tick(1);
          chk("R4 nesting", {7'd0, m_int}, {7'd0, (i < j)});
          if (i < j) begin
            ack_expect("R4 nested vector", 8'h20 + 8'(i));
            wreg(0, 0, 8'h60 + 8'(i));
          end
          wreg(0, 0, 8'h60 + 8'(j));
          @(negedge clk); m_irq[i] = 1'b0; m_irq[j] = 1'b0; tick(1);
          chk("R4 idle", {7'd0, m_int}, 8'h00);
        end
      end
    end

    // pair raised together: lower index wins
    @(negedge clk); m_irq[6] = 1'b1; m_irq[4] = 1'b1; tick(1);
    ack_expect("R4 simultaneous", 8'h24);
    wreg(0, 0, 8'h64);
    ack_expect("R4 simultaneous second", 8'h26);
    wreg(0, 0, 8'h66);
    @(negedge clk); m_irq = '0; tick(1);

    // mask sweep
    for (int n = 0; n < 8; n++) begin
      if (n != 2) begin
        wreg(0, 1, 8'(1) << n);
        rreg(0, 1'b1, v); chk("R3 mask readback", v, 8'(1) << n);
        @(negedge clk); m_irq[n] = 1'b1; tick(1);
        chk("R3 masked input silent", {7'd0, m_int}, 8'h00);
        wreg(0, 1, 8'h00);
        chk("R3 unmasked input", {7'd0, m_int}, 8'h01);
        ack_expect("R3 vector after unmask", 8'h20 + 8'(n));
        wreg(0, 0, 8'h60 + 8'(n));
        @(negedge clk); m_irq[n] = 1'b0; tick(1);
      end
    end

    // nonspecific eoi
    @(negedge clk); m_irq[6] = 1'b1; tick(1);
    ack_expect("R9 first", 8'h26);
    @(negedge clk); m_irq[3] = 1'b1; tick(1);
    ack_expect("R9 second", 8'h23);
    read_isr(0, v); chk("R9 two in service", v, 8'h48);
    wreg(0, 0, 8'h20);
    rreg(0, 1'b0, v); chk("R9 highest cleared", v, 8'h40);
    wreg(0, 0, 8'h20);
    rreg(0, 1'b0, v); chk("R9 last cleared", v, 8'h00);
    wreg(0, 0, 8'h0A);
    @(negedge clk); m_irq = '0; tick(1);

    // spurious
    @(negedge clk); m_irq[5] = 1'b1; tick(1);
    @(negedge clk); m_irq[5] = 1'b0; tick(1);
    chk("R11 request gone", {7'd0, m_int}, 8'h00);
    ack_expect("R11 spurious vector", 8'h27);
    read_isr(0, v); chk("R11 no isr bit", v, 8'h00);

    // automatic eoi
    wreg(0, 0, 8'h11); wreg(0, 1, 8'h20); wreg(0, 1, 8'h04); wreg(0, 1, 8'h03);
    rreg(0, 1'b1, v); chk("R1 mask after reinit", v, 8'h00);
    @(negedge clk); m_irq[4] = 1'b1; tick(1);
    ack_expect("R10 vector", 8'h24);
    read_isr(0, v); chk("R10 isr auto cleared", v, 8'h00);
    @(negedge clk); m_irq[4] = 1'b0; tick(1);

    // single mode, no cascade word
    wreg(0, 0, 8'h13); wreg(0, 1, 8'h30); wreg(0, 1, 8'h01);
    wreg(0, 1, 8'h5A);
    rreg(0, 1'b1, v); chk("R1 single mode mask write", v, 8'h5A);
    wreg(0, 1, 8'h00);
    @(negedge clk); m_irq[7] = 1'b1; tick(1);
    ack_expect("R2 base 0x30", 8'h37);
    wreg(0, 0, 8'h67);
    @(negedge clk); m_irq[7] = 1'b0; tick(1);

    // level mode
    wreg(0, 0, 8'h1B); wreg(0, 1, 8'h30); wreg(0, 1, 8'h01);
    @(negedge clk); m_irq[1] = 1'b1; tick(1);
    ack_expect("R5 level vector", 8'h31);
    rreg(0, 1'b0, v); chk("R5 level irr follows input", v, 8'h02);
    @(negedge clk); m_irq[1] = 1'b0; tick(1);
    rreg(0, 1'b0, v); chk("R5 level irr drops", v, 8'h00);
    wreg(0, 0, 8'h61);
    read_isr(0, v); chk("R8 level isr clear", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule